// File: doc/BRIEF.md
# SDRAM Device Command Decoder

This block is the device-side front end of a four-bank synchronous DRAM model. On every rising clock edge it samples the chip-select, the three command strobes, the clock-enable, the bank select and the 11-bit address bus. It turns each sampled command into a one-cycle decoded strobe. It tracks which banks hold an open row. It captures the bank, row and column values that the rest of the device would use. It also keeps a mode register whose burst length, burst type and read-latency fields are decoded onto their own outputs.

The clock-enable input is modelled as well. When it is sampled low while a row is open, the internal clock is suspended from the next edge and all outputs and latched addresses freeze. When it is sampled low while every bank is idle, the block enters power-down. Both states end when clock-enable is sampled high again, and the following edge accepts commands. The block rejects commands that the bank state does not allow, including mode register writes with reserved bits set. It flags each rejected command instead of acting on it. The memory array, the data path and analog timing are outside this block.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: After reset, cmdStrobe, illegalCmd, bankOpen, suspended, powerDown and modeBusy are 0, the latched bank, row and column are 0, and burstLen, burstType and casLatency are 0.
- R2: A command sampled with csN high gives cmdStrobe = 8'h01 (deselect) one edge later, whatever rasN, casN, weN and the address carry, and it leaves the latched values unchanged.
- R3: With csN low, {rasN,casN,weN} decodes as follows. 111 and 110 are NOP (bit 1, 8'h02). 011 is activate (bit 2). 101 is read (bit 3). 100 is write (bit 4). 010 is precharge (bit 5). 001 is auto-refresh (bit 6). 000 is mode set (bit 7). An accepted command pulses its single bit for one cycle after the sampling edge, and a rejected command pulses illegalCmd with cmdStrobe at 0.
- R4: An accepted activate captures bankSel into latchedBank and addr into rowAddr, and it sets bankOpen[bankSel]. An accepted read or write captures bankSel and addr[7:0] into colAddr.
- R5: An accepted precharge with addr[10] high clears every bankOpen bit. With addr[10] low it clears only bankOpen[bankSel].
- R6: A mode set that is accepted while all banks are idle writes burstLen from addr[2:0], burstType from addr[3] and casLatency from addr[6:4]. modeBusy is then high for the two cycles after the accepting edge.
- R7: A mode set with any of addr[10:7] or bankSel nonzero, or with any bank open, pulses illegalCmd and leaves the mode fields unchanged.
- R8: The following commands are rejected with illegalCmd and have no effect: read or write to a closed bank, activate to an open bank, auto-refresh while any bank is open, and any command other than NOP or deselect while modeBusy is high.
- R9: When cke is sampled low while a bank is open, the command at that edge is still decoded and suspended rises. Later edges produce no strobe and leave every latched value unchanged until cke is sampled high.
- R10: When cke is sampled low while all banks are idle, powerDown rises, and commands are ignored while it stays high.
- R11: The edge that samples cke high again clears suspended and powerDown but ignores its command. The next edge accepts commands normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankSel | input | 2 | Bank address |
| addr | input | 11 | Multiplexed address bus |
| cmdStrobe | output | 8 | One-hot decoded command pulse |
| illegalCmd | output | 1 | Pulse for a rejected command |
| bankOpen | output | 4 | Per-bank open-row flags |
| suspended | output | 1 | Clock suspended with a bank open |
| powerDown | output | 1 | Power-down with all banks idle |
| modeBusy | output | 1 | Mode register write in progress |
| latchedBank | output | 2 | Bank of the last activate, read, write or precharge |
| rowAddr | output | 11 | Row of the last activate |
| colAddr | output | 8 | Column of the last read or write |
| burstLen | output | 3 | Burst length code |
| burstType | output | 1 | Burst type bit |
| casLatency | output | 3 | Read latency code |

## Verification
The bench builds the block with its default parameters: four banks, an 11-bit address and an 8-bit column. With these values every bank-state path can be reached directly. That includes the single-bank and all-banks precharge choices, the A10 all-banks bit, and the reserved mode bits 7 to 10. Two banks are held open at once, so a per-bank precharge can be told apart from an all-banks precharge. The clock-enable sequences cover entry into both suspend and power-down, commands issued during each state, and the exit edge at which a command is still ignored.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int STROBE_W = 8;
  localparam int S_DESEL = 0;
  localparam int S_NOP   = 1;
  localparam int S_ACT   = 2;
  localparam int S_READ  = 3;
  localparam int S_WRITE = 4;
  localparam int S_PRE   = 5;
  localparam int S_REF   = 6;
  localparam int S_MODE  = 7;
  localparam int MODE_BUSY_CYCLES = 2;

  typedef struct packed {
    logic latchBank;
    logic latchRow;
    logic latchCol;
    logic writeMode;
  } ctlStrobe_t;
endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int RSVD_W = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [RSVD_W-1:0]    rsvdAddr,
  input  logic                 allBankBit,
  output logic [STROBE_W-1:0]  cmdStrobe,
  output logic                 illegalCmd,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 suspended,
  output logic                 powerDown,
  output logic                 modeBusy,
  output ctlStrobe_t           ctl
);
  localparam int CNT_W = $clog2(MODE_BUSY_CYCLES + 1);

  logic ckeQ;
  logic [CNT_W-1:0] busyCnt;
  logic [STROBE_W-1:0] strobeNext;
  logic illNext;
  logic [NUM_BANKS-1:0] openNext;
  logic allIdle, selOpen, rsvdBad, busy;

  assign allIdle = (bankOpen == '0);
  assign selOpen = bankOpen[bankSel];
  assign rsvdBad = (|rsvdAddr) || (|bankSel);
  assign busy    = (busyCnt != '0);
  assign modeBusy = busy;

  always_comb begin
    logic isCmd, ok;
    int bitIdx;
    strobeNext = '0;
    illNext    = 1'b0;
    openNext   = bankOpen;
    ctl        = '0;
    isCmd      = 1'b0;
    ok         = 1'b0;
    bitIdx     = S_NOP;
    if (ckeQ) begin
      if (csN) begin
        strobeNext[S_DESEL] = 1'b1;
      end else begin
        case ({rasN, casN, weN})
          3'b011: begin isCmd = 1'b1; bitIdx = S_ACT;   ok = !busy && !selOpen; end
          3'b101: begin isCmd = 1'b1; bitIdx = S_READ;  ok = !busy && selOpen; end
          3'b100: begin isCmd = 1'b1; bitIdx = S_WRITE; ok = !busy && selOpen; end
          3'b010: begin isCmd = 1'b1; bitIdx = S_PRE;   ok = !busy; end
          3'b001: begin isCmd = 1'b1; bitIdx = S_REF;   ok = !busy && allIdle; end
          3'b000: begin isCmd = 1'b1; bitIdx = S_MODE;  ok = !busy && allIdle && !rsvdBad; end
          default: strobeNext[S_NOP] = 1'b1;
        endcase
        if (isCmd) begin
          if (ok) strobeNext[bitIdx] = 1'b1;
          else    illNext = 1'b1;
        end
        if (isCmd && ok) begin
          case (bitIdx)
            S_ACT: begin
              openNext[bankSel] = 1'b1;
              ctl.latchBank = 1'b1;
              ctl.latchRow  = 1'b1;
            end
            S_READ, S_WRITE: begin
              ctl.latchBank = 1'b1;
              ctl.latchCol  = 1'b1;
            end
            S_PRE: begin
              ctl.latchBank = 1'b1;
              if (allBankBit) openNext = '0;
              else            openNext[bankSel] = 1'b0;
            end
            S_MODE: ctl.writeMode = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckeQ       <= 1'b1;
      cmdStrobe  <= '0;
      illegalCmd <= 1'b0;
      bankOpen   <= '0;
      suspended  <= 1'b0;
      powerDown  <= 1'b0;
      busyCnt    <= '0;
    end else begin
      ckeQ       <= cke;
      cmdStrobe  <= strobeNext;
      illegalCmd <= illNext;
      bankOpen   <= openNext;
      suspended  <= !cke && (ckeQ ? !allIdle : suspended);
      powerDown  <= !cke && (ckeQ ? allIdle : powerDown);
      if (ctl.writeMode)
        busyCnt <= CNT_W'(MODE_BUSY_CYCLES);
      else if (ckeQ && busy)
        busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_dpath.sv
module sdcmd_dpath
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W = 11,
  parameter int COL_W = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] latchedBank,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic [2:0]        burstLen,
  output logic              burstType,
  output logic [2:0]        casLatency
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchedBank <= '0;
      rowAddr     <= '0;
      colAddr     <= '0;
      burstLen    <= '0;
      burstType   <= 1'b0;
      casLatency  <= '0;
    end else begin
      if (ctl.latchBank) latchedBank <= bankSel;
      if (ctl.latchRow)  rowAddr     <= addr;
      if (ctl.latchCol)  colAddr     <= addr[COL_W-1:0];
      if (ctl.writeMode) begin
        burstLen   <= addr[2:0];
        burstType  <= addr[3];
        casLatency <= addr[6:4];
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W = 11,
  parameter int COL_W = 8,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int RSVD_LO = 7,
  localparam int AP_BIT = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [ADDR_W-1:0]    addr,
  output logic [7:0]           cmdStrobe,
  output logic                 illegalCmd,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 suspended,
  output logic                 powerDown,
  output logic                 modeBusy,
  output logic [BANK_W-1:0]    latchedBank,
  output logic [ADDR_W-1:0]    rowAddr,
  output logic [COL_W-1:0]     colAddr,
  output logic [2:0]           burstLen,
  output logic                 burstType,
  output logic [2:0]           casLatency
);
  ctlStrobe_t ctl;

  sdcmd_ctrl #(.NUM_BANKS(NUM_BANKS), .RSVD_W(ADDR_W - RSVD_LO)) uCtrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankSel(bankSel), .rsvdAddr(addr[ADDR_W-1:RSVD_LO]),
    .allBankBit(addr[AP_BIT]), .cmdStrobe(cmdStrobe), .illegalCmd(illegalCmd),
    .bankOpen(bankOpen), .suspended(suspended), .powerDown(powerDown),
    .modeBusy(modeBusy), .ctl(ctl)
  );

  sdcmd_dpath #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .COL_W(COL_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bankSel(bankSel), .addr(addr),
    .latchedBank(latchedBank), .rowAddr(rowAddr), .colAddr(colAddr),
    .burstLen(burstLen), .burstType(burstType), .casLatency(casLatency)
  );
endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W = 11,
  parameter int COL_W = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [7:0]           cmdStrobe,
  input logic                 illegalCmd,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 suspended,
  input logic                 powerDown,
  input logic                 modeBusy,
  input logic [COL_W-1:0]     colAddr,
  input logic [ADDR_W-1:0]    rowAddr,
  input logic [2:0]           burstLen
);
  assert_onehot_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdStrobe) && !(illegalCmd && (cmdStrobe != 8'h00)));

  assert_mode_starts_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe[7] |-> (modeBusy && (bankOpen == '0)));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    modeBusy |=> (cmdStrobe[7:2] == 6'b0));

  assert_refresh_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe[6] |-> (bankOpen == '0));

  assert_suspend_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    suspended |=> (cmdStrobe == 8'h00) && $stable(colAddr) && $stable(rowAddr) && $stable(bankOpen));

  assert_powerdown_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (cmdStrobe == 8'h00) && !illegalCmd && $stable(burstLen));

  assert_states_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(suspended && powerDown));
endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .COL_W(COL_W)
) chk (.*);

// File: tb/sdram_cmd_decoder_test.sv
module sdram_cmd_decoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] bankSel = '0;
  logic [10:0] addr = '0;
  logic [7:0] cmdStrobe;
  logic illegalCmd, suspended, powerDown, modeBusy, burstType;
  logic [3:0] bankOpen;
  logic [1:0] latchedBank;
  logic [10:0] rowAddr;
  logic [7:0] colAddr;
  logic [2:0] burstLen, casLatency;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_cmd_decoder uut (.*);

  // {csN,rasN,casN,weN}, bank, addr, expected strobe, expected illegal, expected bankOpen
  localparam logic [29:0] VEC [0:18] = '{
    {4'b1000, 2'd0, 11'h7FF, 8'h01, 1'b0, 4'h0},
    {4'b0111, 2'd0, 11'h000, 8'h02, 1'b0, 4'h0},
    {4'b0110, 2'd0, 11'h000, 8'h02, 1'b0, 4'h0},
    {4'b0000, 2'd0, 11'h032, 8'h80, 1'b0, 4'h0},
    {4'b0111, 2'd0, 11'h000, 8'h02, 1'b0, 4'h0},
    {4'b0011, 2'd1, 11'h155, 8'h00, 1'b1, 4'h0},
    {4'b0011, 2'd1, 11'h155, 8'h04, 1'b0, 4'h2},
    {4'b0101, 2'd1, 11'h0AB, 8'h08, 1'b0, 4'h2},
    {4'b0100, 2'd2, 11'h010, 8'h00, 1'b1, 4'h2},
    {4'b0011, 2'd2, 11'h200, 8'h04, 1'b0, 4'h6},
    {4'b0011, 2'd2, 11'h201, 8'h00, 1'b1, 4'h6},
    {4'b0001, 2'd0, 11'h000, 8'h00, 1'b1, 4'h6},
    {4'b0000, 2'd0, 11'h000, 8'h00, 1'b1, 4'h6},
    {4'b0010, 2'd1, 11'h000, 8'h20, 1'b0, 4'h4},
    {4'b0100, 2'd1, 11'h000, 8'h00, 1'b1, 4'h4},
    {4'b0100, 2'd2, 11'h07F, 8'h10, 1'b0, 4'h4},
    {4'b0010, 2'd0, 11'h400, 8'h20, 1'b0, 4'h0},
    {4'b0001, 2'd0, 11'h000, 8'h40, 1'b0, 4'h0},
    {4'b0000, 2'd0, 11'h080, 8'h00, 1'b1, 4'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, wait for the sampling edge, return at the next falling edge
  task automatic issue(input logic k, input logic [3:0] c, input logic [1:0] b, input logic [10:0] a);
    cke = k;
    {csN, rasN, casN, weN} = c;
    bankSel = b;
    addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 strobe", cmdStrobe, 0);
    chk("R1 flags", {illegalCmd, suspended, powerDown, modeBusy, bankOpen}, 0);
    chk("R1 latched", {latchedBank, rowAddr, colAddr}, 0);
    chk("R1 mode", {burstLen, burstType, casLatency}, 0);

    for (int i = 0; i < 19; i++) begin
      issue(1'b1, VEC[i][29:26], VEC[i][25:24], VEC[i][23:13]);
      chk($sformatf("R3 vector %0d strobe", i), cmdStrobe, VEC[i][12:5]);
      chk($sformatf("R8 vector %0d illegal", i), illegalCmd, VEC[i][4]);
      chk($sformatf("R5 vector %0d bankOpen", i), bankOpen, VEC[i][3:0]);
    end

    chk("R7 mode unchanged", {burstLen, burstType, casLatency}, {3'd2, 1'b0, 3'd3});

    issue(1'b1, 4'b0000, 2'd0, 11'h02B);
    chk("R6 mode strobe", cmdStrobe, 8'h80);
    chk("R6 mode fields", {burstLen, burstType, casLatency}, {3'd3, 1'b1, 3'd2});
    chk("R6 busy first", modeBusy, 1);
    issue(1'b1, 4'b0111, 2'd0, 11'h000);
    chk("R6 busy second", modeBusy, 1);
    issue(1'b1, 4'b0111, 2'd0, 11'h000);
    chk("R6 busy done", modeBusy, 0);

    issue(1'b1, 4'b0011, 2'd3, 11'h3FF);
    chk("R4 activate latch", {latchedBank, rowAddr}, {2'd3, 11'h3FF});
    issue(1'b1, 4'b0101, 2'd3, 11'h5CD);
    chk("R4 read col", {latchedBank, colAddr}, {2'd3, 8'hCD});
    issue(1'b1, 4'b1000, 2'd0, 11'h0FF);
    chk("R2 deselect strobe", cmdStrobe, 8'h01);
    chk("R2 deselect no effect", {colAddr, bankOpen}, {8'hCD, 4'h8});

    issue(1'b0, 4'b0101, 2'd3, 11'h011);
    chk("R9 entry edge decoded", {cmdStrobe, colAddr}, {8'h08, 8'h11});
    chk("R9 suspended", {suspended, powerDown}, 2'b10);
    issue(1'b0, 4'b0101, 2'd3, 11'h022);
    chk("R9 frozen", {cmdStrobe, colAddr, suspended}, {8'h00, 8'h11, 1'b1});
    issue(1'b1, 4'b0101, 2'd3, 11'h033);
    chk("R11 exit edge ignored", {cmdStrobe, colAddr, suspended}, {8'h00, 8'h11, 1'b0});
    issue(1'b1, 4'b0101, 2'd3, 11'h044);
    chk("R11 accepted after exit", {cmdStrobe, colAddr}, {8'h08, 8'h44});

    issue(1'b1, 4'b0010, 2'd0, 11'h400);
    chk("R5 precharge all", bankOpen, 0);
    issue(1'b0, 4'b0111, 2'd0, 11'h000);
    chk("R10 power-down entry", {suspended, powerDown}, 2'b01);
    issue(1'b0, 4'b0011, 2'd0, 11'h000);
    chk("R10 ignored", {cmdStrobe, illegalCmd, bankOpen, powerDown}, {8'h00, 1'b0, 4'h0, 1'b1});
    issue(1'b1, 4'b0011, 2'd0, 11'h000);
    chk("R11 power-down exit edge", {cmdStrobe, bankOpen, powerDown}, {8'h00, 4'h0, 1'b0});
    issue(1'b1, 4'b0011, 2'd0, 11'h000);
    chk("R11 activate after exit", {cmdStrobe, bankOpen}, {8'h04, 4'h1});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule